// File: doc/BRIEF.md
# Indexed and Indirect-Indexed Address Sequencer

This block turns one decoded memory-operand command into the accesses it needs on a data memory port. A command names a base index register, a 16-bit offset, an access width, a load or store direction and, for the indirect form, a post-index register. In the indexed form the block makes one access at base plus offset. In the indirect-indexed form it first reads a pointer word at base plus offset, adds the post-index register to it, and then makes the operand access at that sum. Loads return the operand on a result stream, with byte reads zero-extended to 16 bits. Stores write the supplied value and return nothing.

All older absolute and zero-page addressing forms are folded into one base-plus-offset form. One of the four index selections is a hardwired zero, so an absolute address is written as zero plus offset. The older pre-indexed indirect form becomes a pointer read at X plus offset, followed by a zero post-index. Read-modify-write is not offered. Each command is either a load or a store.

Commands enter on a valid/ready stream. The block accepts one command only when it is idle, and `cmd_ready` stays low from acceptance until the command has fully retired. Results leave on a valid/ready stream. A result is held, unchanged, until the consumer takes it, and the block accepts no new command while a result is waiting. The memory port has one access outstanding at a time. The request and all of its fields stay asserted until the memory returns a one-cycle done pulse.

Top module: `idx_addr_seq`

## Requirements
- R1: During and after reset, until a command arrives, `cmd_ready`=1, `busy`=0, `mem_req`=0 and `res_valid`=0.
- R2: The base select and post select use the same encoding: 0 selects S, 1 selects X, 2 selects Y, and 3 selects a constant zero. Both index values are taken in the cycle the command is accepted. Later changes to the index inputs do not affect that command.
- R3: An indexed command makes exactly one memory access, at base plus offset modulo 2^16.
- R4: An indirect command makes exactly two accesses. The first is a word read (`mem_we`=0, `mem_be`=2'b11) at base plus offset. The second is at the returned pointer plus the post-index value, modulo 2^16.
- R5: The operand access has `mem_be`=2'b11 for a word (`cmd_byte`=0). For a byte (`cmd_byte`=1), `mem_be` is 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R6: A word load returns `mem_rdata` unchanged. A byte load returns `mem_rdata[7:0]` for an even address or `mem_rdata[15:8]` for an odd address, in bits 7:0, with bits 15:8 zero.
- R7: A store drives `mem_we`=1 on its operand access. A word store drives `cmd_wdata` on `mem_wdata`. A byte store drives the low byte of `cmd_wdata` on both byte lanes. A store produces no result beat, and `busy` falls in the cycle after its done pulse.
- R8: `mem_req` stays high, with `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` stable, until the cycle in which `mem_done` is high.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold. `busy`=1 and `cmd_ready`=0 stay in force until the result is taken, and a command offered meanwhile is not accepted.
- R10: With base select 3, the access address equals the offset. With base select 1 and post select 3, the operand address equals the pointer read at X plus offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted at this edge if valid |
| cmd_indirect | input | 1 | 1 = pointer read then post-indexed access |
| cmd_byte | input | 1 | 1 = byte access, 0 = word access |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | 2 | Base index select |
| cmd_post | input | 2 | Post index select (indirect only) |
| cmd_offset | input | 16 | Offset added to the base |
| cmd_wdata | input | 16 | Store value |
| reg_s | input | 16 | Current S index value |
| reg_x | input | 16 | Current X index value |
| reg_y | input | 16 | Current Y index value |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 16 | Byte address of the access |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Write data, lane-placed |
| mem_done | input | 1 | One-cycle completion of the current access |
| mem_rdata | input | 16 | Read data, valid with `mem_done` |
| res_valid | output | 1 | Load result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Load result |
| busy | output | 1 | Command in progress or result waiting |

## Verification
The bench builds the block with its defaults: 16-bit addresses and a 16-bit data bus split into two byte lanes. These widths bring address wrap-around at 2^16 within reach, along with both lane choices for byte reads and writes. The bench's memory model answers each request after a latency it chooses per command. This exercises both the held-request rule and the pointer phase followed straight away by the operand request. Directed cases stall the result stream while another command is offered, and they change an index input after acceptance to show that the value taken at acceptance is the one used.

// File: rtl/ias_pkg.sv
package ias_pkg;
  typedef enum logic [1:0] {
    IDX_S    = 2'd0,
    IDX_X    = 2'd1,
    IDX_Y    = 2'd2,
    IDX_ZERO = 2'd3
  } idx_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_OPND = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic indirect;
    logic byte_w;
    logic store;
  } acc_kind_t;
endpackage

// File: rtl/ias_index_sel.sv
module ias_index_sel
  import ias_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] val_s,
  input  logic [AW-1:0] val_x,
  input  logic [AW-1:0] val_y,
  output logic [AW-1:0] val_out
);
  always_comb begin
    case (idx_sel_e'(sel))
      IDX_S:   val_out = val_s;
      IDX_X:   val_out = val_x;
      IDX_Y:   val_out = val_y;
      default: val_out = '0;
    endcase
  end
endmodule

// File: rtl/ias_lane.sv
module ias_lane #(
  parameter int DW = 16
) (
  input  logic          byte_w,
  input  logic          hi_lane,
  input  logic [DW-1:0] wr_in,
  input  logic [DW-1:0] rd_in,
  output logic [1:0]    be,
  output logic [DW-1:0] wr_out,
  output logic [DW-1:0] rd_out
);
  localparam int BW = DW / 2;

  logic [BW-1:0] rd_byte;

  // Byte stores replicate the low byte into every lane; the enable picks the lane.
  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign wr_out[i*BW +: BW] = byte_w ? wr_in[BW-1:0] : wr_in[i*BW +: BW];
  end

  assign rd_byte = hi_lane ? rd_in[DW-1:BW] : rd_in[BW-1:0];
  assign rd_out  = byte_w ? {{(DW-BW){1'b0}}, rd_byte} : rd_in;
  assign be      = byte_w ? (hi_lane ? 2'b10 : 2'b01) : 2'b11;
endmodule

// File: rtl/ias_ctrl.sv
module ias_ctrl
  import ias_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_indirect,
  input  logic          cmd_byte,
  input  logic          cmd_store,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] post_val,
  input  logic [AW-1:0] cmd_offset,
  input  logic [DW-1:0] cmd_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          busy
);
  seq_state_e    state_q;
  acc_kind_t     kind_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] post_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] res_q;
  logic [1:0]    lane_be;
  logic [DW-1:0] lane_wr;
  logic [DW-1:0] lane_rd;
  logic          accept;

  ias_lane #(.DW(DW)) u_lane (
    .byte_w (kind_q.byte_w),
    .hi_lane(addr_q[0]),
    .wr_in  (wdata_q),
    .rd_in  (mem_rdata),
    .be     (lane_be),
    .wr_out (lane_wr),
    .rd_out (lane_rd)
  );

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= '0;
      addr_q  <= '0;
      post_q  <= '0;
      wdata_q <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= base_val + cmd_offset;
          post_q  <= post_val;
          wdata_q <= cmd_wdata;
          kind_q  <= '{indirect: cmd_indirect, byte_w: cmd_byte, store: cmd_store};
          state_q <= cmd_indirect ? ST_PTR : ST_OPND;
        end
        ST_PTR: if (mem_done) begin
          addr_q  <= AW'(mem_rdata) + post_q;
          state_q <= ST_OPND;
        end
        ST_OPND: if (mem_done) begin
          if (kind_q.store) begin
            state_q <= ST_IDLE;
          end else begin
            res_q   <= lane_rd;
            state_q <= ST_RESP;
          end
        end
        default: if (res_ready) state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (state_q == ST_PTR) || (state_q == ST_OPND);
  assign mem_we    = (state_q == ST_OPND) && kind_q.store;
  assign mem_addr  = addr_q;
  assign mem_be    = (state_q == ST_PTR) ? 2'b11 : lane_be;
  assign mem_wdata = lane_wr;
  assign res_valid = (state_q == ST_RESP);
  assign res_data  = res_q;
  assign busy      = (state_q != ST_IDLE);

  // R8: request and its fields held until done
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_be) && $stable(mem_wdata)));

  // R5: enables are never empty while requesting
  a_r5_be_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) != 0));

  // R4: the pointer phase completes into a read-only transition to the operand phase
  a_r4_ptr_then_opnd: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PTR && mem_done) |=> (mem_req && state_q == ST_OPND));

  // R4: the pointer read is a full-word read
  a_r4_ptr_read_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PTR) |-> (!mem_we && mem_be == 2'b11));

  // R7: a completed store retires with no result beat
  a_r7_store_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_done) |=> (!res_valid && !busy));

  // R9: result held under back-pressure
  a_r9_res_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R9: ready only when nothing is in flight
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req && !res_valid));
endmodule

// File: rtl/idx_addr_seq.sv
module idx_addr_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_indirect,
  input  logic          cmd_byte,
  input  logic          cmd_store,
  input  logic [1:0]    cmd_base,
  input  logic [1:0]    cmd_post,
  input  logic [AW-1:0] cmd_offset,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [AW-1:0] reg_s,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          busy
);
  localparam int NSEL = 2;

  logic [1:0]    sel_v [NSEL];
  logic [AW-1:0] idx_v [NSEL];

  assign sel_v[0] = cmd_base;
  assign sel_v[1] = cmd_post;

  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    ias_index_sel #(.AW(AW)) u_sel (
      .sel    (sel_v[k]),
      .val_s  (reg_s),
      .val_x  (reg_x),
      .val_y  (reg_y),
      .val_out(idx_v[k])
    );
  end

  ias_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_indirect(cmd_indirect),
    .cmd_byte    (cmd_byte),
    .cmd_store   (cmd_store),
    .base_val    (idx_v[0]),
    .post_val    (idx_v[1]),
    .cmd_offset  (cmd_offset),
    .cmd_wdata   (cmd_wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_wdata   (mem_wdata),
    .mem_done    (mem_done),
    .mem_rdata   (mem_rdata),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .busy        (busy)
  );
endmodule

// File: tb/sim_idx_addr_seq.sv
module sim_idx_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [15:0] S_VAL = 16'h01F0;
  localparam logic [15:0] X_VAL = 16'h0022;
  localparam logic [15:0] Y_VAL = 16'h0305;
  // {indirect, byte, store, base[2], post[2], lat[3], offset[16], wdata[16]}
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 3'd0, 16'h0010, 16'h0000},
    {1'b0, 1'b1, 1'b0, 2'd2, 2'd3, 3'd1, 16'h0004, 16'h0000},
    {1'b0, 1'b1, 1'b0, 2'd0, 2'd3, 3'd2, 16'h0010, 16'h0000},
    {1'b0, 1'b0, 1'b1, 2'd3, 2'd3, 3'd2, 16'h1234, 16'hBEEF},
    {1'b0, 1'b1, 1'b1, 2'd1, 2'd3, 3'd0, 16'h0001, 16'h12AB},
    {1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 3'd1, 16'h0006, 16'h0000},
    {1'b1, 1'b1, 1'b0, 2'd3, 2'd1, 3'd3, 16'h0080, 16'h0000},
    {1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 3'd0, 16'h0011, 16'h5566},
    {1'b1, 1'b0, 1'b0, 2'd1, 2'd3, 3'd2, 16'h0040, 16'h0000},
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd3, 3'd4, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_indirect = 1'b0, cmd_byte = 1'b0, cmd_store = 1'b0;
  logic [1:0] cmd_base = '0, cmd_post = '0;
  logic [15:0] cmd_offset = '0, cmd_wdata = '0;
  logic [15:0] reg_s = S_VAL, reg_x = X_VAL, reg_y = Y_VAL;
  logic cmd_ready, mem_req, mem_we, res_valid, busy;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, res_data;
  logic [1:0] mem_be;
  logic mem_done = 1'b0;
  logic res_ready = 1'b1;
  logic [2:0] lat_cfg = '0;
  logic [2:0] lat_cnt = '0;
  int total_n = 0;
  logic [15:0] lg_addr [64];
  logic [15:0] lg_wdata [64];
  logic [1:0]  lg_be [64];
  logic        lg_we [64];
  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_indirect(cmd_indirect), .cmd_byte(cmd_byte), .cmd_store(cmd_store),
    .cmd_base(cmd_base), .cmd_post(cmd_post), .cmd_offset(cmd_offset),
    .cmd_wdata(cmd_wdata), .reg_s(reg_s), .reg_x(reg_x), .reg_y(reg_y),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .busy(busy)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    logic [15:0] w;
    w = {a[15:1], 1'b0};
    return {w[7:0], w[15:8]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] idx_val(input logic [1:0] s);
    case (s)
      2'd0: return S_VAL;
      2'd1: return X_VAL;
      2'd2: return Y_VAL;
      default: return 16'h0000;
    endcase
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  // Memory model: done after lat_cfg extra cycles; logs each access.
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_done <= 1'b0;
      lat_cnt  <= '0;
    end else if (mem_done) begin
      mem_done <= 1'b0;
      lat_cnt  <= '0;
    end else if (mem_req) begin
      if (lat_cnt == lat_cfg) begin
        mem_done <= 1'b1;
        lg_addr[total_n % 64]  <= mem_addr;
        lg_wdata[total_n % 64] <= mem_wdata;
        lg_be[total_n % 64]    <= mem_be;
        lg_we[total_n % 64]    <= mem_we;
        total_n <= total_n + 1;
      end else begin
        lat_cnt <= lat_cnt + 3'd1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail);
      $finish;
    end
  end

  task automatic drive(input logic [41:0] v);
    {cmd_indirect, cmd_byte, cmd_store, cmd_base, cmd_post, lat_cfg, cmd_offset, cmd_wdata} = v;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R1 reset ready/busy", {cmd_ready, busy}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0 && res_valid == 1'b0 && cmd_ready == 1'b1 && busy == 1'b0,
        "R1 idle after reset", {mem_req, res_valid, cmd_ready, busy}, 4'b0010);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v;
      logic ind, byt, st;
      logic [1:0] bs, ps;
      logic [15:0] off, wd, ea1, ea2, ptr, rdw, exp_d, got_d, exp_w;
      logic [1:0] exp_be;
      int start, n_exp, last;
      bit res_seen;
      v = VEC[i];
      {ind, byt, st, bs, ps} = v[41:35];
      off = v[31:16];
      wd  = v[15:0];
      ea1 = idx_val(bs) + off;
      ptr = mem_word(ea1);
      ea2 = ind ? ptr + idx_val(ps) : ea1;
      n_exp = ind ? 2 : 1;
      rdw = mem_word(ea2);
      exp_d = byt ? {8'h00, (ea2[0] ? rdw[15:8] : rdw[7:0])} : rdw;
      exp_be = byt ? (ea2[0] ? 2'b10 : 2'b01) : 2'b11;
      exp_w = byt ? {wd[7:0], wd[7:0]} : wd;
      start = total_n;
      res_seen = 1'b0;
      got_d = '0;
      drive(v);
      if (st) begin
        while (busy) begin
          if (res_valid) res_seen = 1'b1;
          @(negedge clk);
        end
      end else begin
        while (!res_valid) @(negedge clk);
        got_d = res_data;
        @(negedge clk);
      end
      last = (total_n - 1) % 64;
      chk(total_n - start == n_exp, ind ? "R4 access count" : "R3 access count",
          total_n - start, n_exp);
      chk(lg_addr[start % 64] == ea1, (bs == 2'd3) ? "R10 zero base address" : "R2 first address",
          lg_addr[start % 64], ea1);
      if (ind) begin
        chk(lg_we[start % 64] == 1'b0 && lg_be[start % 64] == 2'b11, "R4 pointer word read",
            {lg_we[start % 64], lg_be[start % 64]}, 3'b011);
        chk(lg_addr[last] == ea2, (ps == 2'd3) ? "R10 pre-indexed operand address" : "R4 operand address",
            lg_addr[last], ea2);
      end
      chk(lg_be[last] == exp_be, "R5 byte enables", lg_be[last], exp_be);
      chk(lg_we[last] == st, "R7 write flag", lg_we[last], st);
      if (st) begin
        chk(lg_wdata[last] == exp_w, "R7 store data", lg_wdata[last], exp_w);
        chk(!res_seen && !busy, "R7 no result beat", {res_seen, busy}, 2'b00);
      end else begin
        chk(got_d == exp_d, "R6 load data", got_d, exp_d);
      end
    end

    // R2: index value taken at acceptance
    begin
      logic [15:0] ea;
      int start;
      ea = X_VAL + 16'h0100;
      start = total_n;
      drive({1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 3'd3, 16'h0100, 16'h0000});
      reg_x = 16'h7777;
      while (!res_valid) @(negedge clk);
      @(negedge clk);
      chk(lg_addr[start % 64] == ea, "R2 index sampled at accept", lg_addr[start % 64], ea);
      reg_x = X_VAL;
    end

    // R9: result back-pressure with a competing command
    begin
      logic [15:0] ea1, ea2, exp_d, held;
      int n_before;
      ea1 = Y_VAL + 16'h0020;
      ea2 = mem_word(ea1) + S_VAL;
      exp_d = mem_word(ea2);
      res_ready = 1'b0;
      drive({1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 3'd1, 16'h0020, 16'h0000});
      while (!res_valid) @(negedge clk);
      held = res_data;
      n_before = total_n;
      chk(held == exp_d, "R9 stalled result value", held, exp_d);
      cmd_indirect = 1'b0; cmd_base = 2'd3; cmd_offset = 16'h4000; cmd_valid = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(res_valid && res_data == held && busy && !cmd_ready, "R9 result held",
            {res_valid, busy, cmd_ready, res_data}, {3'b110, held});
      end
      chk(total_n == n_before, "R9 no access while stalled", total_n, n_before);
      cmd_valid = 1'b0;
      res_ready = 1'b1;
      @(negedge clk);
      chk(!res_valid && !busy && cmd_ready, "R9 released", {res_valid, busy, cmd_ready}, 3'b001);
    end

    // R8: request held during long latency
    begin
      logic [15:0] a0;
      bit stable_ok;
      stable_ok = 1'b1;
      drive({1'b0, 1'b1, 1'b1, 2'd2, 2'd3, 3'd5, 16'h0002, 16'h00C3});
      a0 = mem_addr;
      while (busy) begin
        if (!mem_done && (!mem_req || mem_addr != a0 || !mem_we || mem_be != 2'b10)) stable_ok = 1'b0;
        @(negedge clk);
      end
      chk(stable_ok, "R8 request held until done", {mem_req, mem_addr}, {1'b1, a0});
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule